// File: doc/BRIEF.md
# Cascadable Serial Bit-Stream Memory

This block is a read-only store of a fixed bit stream that a device loader reads one bit per clock. An internal address counter selects the bit shown on a single serial data line. The counter steps forward on every rising clock edge on which the device is selected. Selection comes from an active-low chip-enable input. A combined reset/output-enable pin clears the counter and floats the output. The level at which that pin counts as active is chosen by a parameter.

Several devices can form a chain that behaves as one longer memory. The cascade output of one device drives the chip-enable of the next. When the last stored bit has been shown, the next enabled clock pulls the cascade output low and the device releases the data line, so the next device takes over. The data line is modelled as a value plus a drive-enable, which lets a bench find contention between neighbours. If the reset pin is never made active, the counter keeps its position between loads. A later load then resumes from that address.

Top module: `scr_mem`

## Requirements
- R1: While the reset/output-enable pin is at its active level, `dout_en` is 0 at once. After the next rising clock the read position is address 0 and `cas_n` is 1.
- R2: With `RST_ACTIVE_HIGH`=1 the pin is active when 1. With `RST_ACTIVE_HIGH`=0 it is active when 0, and a high level on it then lets the device run.
- R3: When `ce_n`=0, reset is inactive and the stream is not used up, `dout_en`=1 and `dout` equals `PATTERN[k]`, where k is the current address. Address 0 is the least significant bit of `PATTERN`.
- R4: Each rising clock while the device drives the line moves the address up by exactly one, so consecutive clocks show consecutive bits.
- R5: While `ce_n`=1, `dout_en` is 0 and the address does not change on any clock.
- R6: `cas_n` is 1 while bits 0 to `DEPTH`-1 are shown. The enabled clock after bit `DEPTH`-1 sets `cas_n` to 0 and `dout_en` to 0.
- R7: Once low, `cas_n` stays low through further clocks and changes of `ce_n`, until a reset.
- R8: With reset kept inactive, deselecting and then reselecting the device resumes at the address where it stopped.
- R9: In a chain where the cascade output of one device drives the next device's `ce_n`, the downstream device drives the line starting with its bit 0 as soon as the upstream device finishes. No two devices drive the line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; address steps on the rising edge |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| cas_n | output | 1 | Cascade enable to the next device, low once the stream is used up |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Drive enable of `dout`; 0 models high impedance |

## Verification
The bench checks the handover in a two-device chain cycle by cycle. A design that advanced one clock too early or too late would lose the final upstream bit, repeat it, or drive both devices at once, and the bench would report contention or a wrong bit. It deselects the upstream device in the middle of the stream and then reselects it. A counter that drifted or cleared would resume at the wrong bit. It also resets a device that has run out, checking that the cascade output goes high again and reading restarts at bit 0. It runs an inverted-polarity device, where a wrongly decoded pin would either never run or never clear.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic {
        PH_ACTIVE = 1'b0,
        PH_SPENT  = 1'b1
    } scr_phase_e;

    function automatic int unsigned scr_addr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/scr_ctr.sv
module scr_ctr
    import scr_pkg::*;
#(
    parameter int unsigned DEPTH = 24,
    localparam int unsigned AW   = scr_addr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          ce_n,
    output logic [AW-1:0] addr,
    output logic          spent
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        scr_phase_e    phase;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d = st_q;
        adv  = !ce_n && (st_q.phase == PH_ACTIVE);
        if (rst_act) begin
            st_d.addr  = '0;
            st_d.phase = PH_ACTIVE;
        end else if (adv) begin
            if (st_q.addr == LAST) begin
                st_d.phase = PH_SPENT;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr  = st_q.addr;
    assign spent = (st_q.phase == PH_SPENT);

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk)
        rst_act |=> (addr == '0 && !spent)) else $error("clear failed"); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst_act)
        (!ce_n && !spent && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1))); // R4
    AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |=> $stable(addr)); // R5
    AST_SPENT_STICKY: assert property (@(posedge clk) disable iff (rst_act)
        spent |=> spent); // R7
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst_act)
        addr <= LAST); // R6

endmodule

// File: rtl/scr_bit_rom.sv
module scr_bit_rom
    import scr_pkg::*;
#(
    parameter int unsigned      DEPTH   = 24,
    parameter logic [DEPTH-1:0] PATTERN = '0,
    localparam int unsigned     AW      = scr_addr_width(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          bit_o
);

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (addr == AW'(i)) begin
                bit_o = PATTERN[i];
            end
        end
    end

endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage (
    input  logic clk,
    input  logic ce_n,
    input  logic rst_act,
    input  logic spent,
    input  logic rom_bit,
    output logic dout,
    output logic dout_en,
    output logic cas_n
);

    assign dout_en = !ce_n && !rst_act && !spent;
    assign dout    = dout_en ? rom_bit : 1'b0;
    assign cas_n   = !spent;

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst_act)
        dout_en |-> (!ce_n && cas_n)); // R5
    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst_act |-> !dout_en); // R1

endmodule

// File: rtl/scr_mem.sv
module scr_mem
    import scr_pkg::*;
#(
    parameter int unsigned      DEPTH           = 24,
    parameter logic [DEPTH-1:0] PATTERN         = 24'h9C5AE3,
    parameter bit               RST_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic ce_n,
    input  logic rst_oe,
    output logic cas_n,
    output logic dout,
    output logic dout_en
);

    localparam int unsigned AW = scr_addr_width(DEPTH);

    logic          rst_act;
    logic [AW-1:0] addr;
    logic          spent;
    logic          rom_bit;

    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_hi
            assign rst_act = rst_oe;
        end else begin : g_rst_lo
            assign rst_act = !rst_oe;
        end
    endgenerate

    scr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk     (clk),
        .rst_act (rst_act),
        .ce_n    (ce_n),
        .addr    (addr),
        .spent   (spent)
    );

    scr_bit_rom #(.DEPTH(DEPTH), .PATTERN(PATTERN)) u_rom (
        .addr  (addr),
        .bit_o (rom_bit)
    );

    scr_out_stage u_out (
        .clk     (clk),
        .ce_n    (ce_n),
        .rst_act (rst_act),
        .spent   (spent),
        .rom_bit (rom_bit),
        .dout    (dout),
        .dout_en (dout_en),
        .cas_n   (cas_n)
    );

    AST_CASCADE_RELEASE: assert property (@(posedge clk) disable iff (rst_act)
        (!ce_n && cas_n && !dout_en) |-> 1'b0) else $error("selected but silent"); // R3
    AST_CASCADE_HIGH_AFTER_CLEAR: assert property (@(posedge clk)
        rst_act |=> cas_n); // R6

endmodule

// File: tb/scr_mem_bench.sv
module scr_mem_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DA = 24;
    localparam int DB = 12;
    localparam int DC = 8;
    localparam logic [DA-1:0] PAT_A = 24'h9C5AE3;
    localparam logic [DB-1:0] PAT_B = 12'hB61;
    localparam logic [DC-1:0] PAT_C = 8'h6D;

    logic clk = 1'b0;
    logic rst_hi, ce_a, rst_c, ce_c;
    logic cas_a, dout_a, en_a;
    logic cas_b, dout_b, en_b;
    logic cas_c, dout_c, en_c;
    int   total = 0;
    int   bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scr_mem #(.DEPTH(DA), .PATTERN(PAT_A), .RST_ACTIVE_HIGH(1'b1)) u_scr_mem (
        .clk(clk), .ce_n(ce_a), .rst_oe(rst_hi),
        .cas_n(cas_a), .dout(dout_a), .dout_en(en_a));

    scr_mem #(.DEPTH(DB), .PATTERN(PAT_B), .RST_ACTIVE_HIGH(1'b1)) u_scr_mem_b (
        .clk(clk), .ce_n(cas_a), .rst_oe(rst_hi),
        .cas_n(cas_b), .dout(dout_b), .dout_en(en_b));

    scr_mem #(.DEPTH(DC), .PATTERN(PAT_C), .RST_ACTIVE_HIGH(1'b0)) u_scr_mem_c (
        .clk(clk), .ce_n(ce_c), .rst_oe(rst_c),
        .cas_n(cas_c), .dout(dout_c), .dout_en(en_c));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // one chain cycle: check exactly one driver, then the expected bit
    task automatic chain_bit(input bit from_b, input bit exp_bit, input string req);
        chk(!(en_a && en_b), "R9 contention", int'(en_a && en_b), 0);
        if (from_b) begin
            chk(en_b === 1'b1 && en_a === 1'b0, {req, " drv"}, int'(en_b), 1);
            chk(dout_b === exp_bit, req, int'(dout_b), int'(exp_bit));
        end else begin
            chk(en_a === 1'b1, {req, " drv"}, int'(en_a), 1);
            chk(dout_a === exp_bit, req, int'(dout_a), int'(exp_bit));
        end
    endtask

    task automatic t_reset();
        rst_hi = 1'b1; ce_a = 1'b0; rst_c = 1'b0; ce_c = 1'b0;
        repeat (2) step();
        chk(en_a === 1'b0, "R1 en_a in reset", int'(en_a), 0);
        chk(en_b === 1'b0, "R1 en_b in reset", int'(en_b), 0);
        chk(cas_a === 1'b1, "R1 cas_a after reset", int'(cas_a), 1);
        chk(en_c === 1'b0, "R2 low-active reset quiet", int'(en_c), 0);
    endtask

    task automatic t_chain();
        rst_hi = 1'b0;
        #1;
        for (int k = 0; k < 10; k++) begin
            chain_bit(1'b0, PAT_A[k], "R3 bit A");
            step();
        end
        ce_a = 1'b1;
        #1;
        chk(en_a === 1'b0, "R5 deselected quiet", int'(en_a), 0);
        repeat (3) step();
        chk(en_a === 1'b0, "R5 still quiet", int'(en_a), 0);
        ce_a = 1'b0;
        #1;
        chk(dout_a === PAT_A[10], "R8 resume bit 10", int'(dout_a), int'(PAT_A[10]));
        for (int k = 10; k < DA; k++) begin
            chain_bit(1'b0, PAT_A[k], "R4 bit A");
            chk(cas_a === 1'b1, "R6 cas high before end", int'(cas_a), 1);
            step();
        end
        chk(cas_a === 1'b0, "R6 cas low after last", int'(cas_a), 0);
        chk(en_a === 1'b0, "R6 A released", int'(en_a), 0);
        for (int k = 0; k < DB; k++) begin
            chain_bit(1'b1, PAT_B[k], "R9 bit B");
            step();
        end
        chk(cas_b === 1'b0, "R6 B cascade low", int'(cas_b), 0);
        chk(en_b === 1'b0, "R6 B released", int'(en_b), 0);
        repeat (3) step();
        ce_a = 1'b1;
        step();
        ce_a = 1'b0;
        step();
        chk(cas_a === 1'b0, "R7 cas sticky", int'(cas_a), 0);
        chk(en_a === 1'b0, "R7 A stays silent", int'(en_a), 0);
    endtask

    task automatic t_rereset();
        rst_hi = 1'b1;
        #1;
        chk(en_a === 1'b0, "R1 immediate float", int'(en_a), 0);
        step();
        chk(cas_a === 1'b1, "R1 cas restored", int'(cas_a), 1);
        rst_hi = 1'b0;
        #1;
        chk(en_a === 1'b1 && dout_a === PAT_A[0], "R1 restart bit 0", int'(dout_a), int'(PAT_A[0]));
        step();
        chk(dout_a === PAT_A[1], "R4 restart bit 1", int'(dout_a), int'(PAT_A[1]));
    endtask

    task automatic t_polarity();
        rst_c = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            chk(en_c === 1'b1 && dout_c === PAT_C[k], "R2 runs with pin high", int'(dout_c), int'(PAT_C[k]));
            step();
        end
        rst_c = 1'b0;
        #1;
        chk(en_c === 1'b0, "R2 low level floats", int'(en_c), 0);
        step();
        rst_c = 1'b1;
        #1;
        chk(dout_c === PAT_C[0], "R2 low level clears", int'(dout_c), int'(PAT_C[0]));
    endtask

    initial begin
        t_reset();
        t_chain();
        t_rereset();
        t_polarity();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule